// File: doc/BRIEF.md
# Programmable Pixel Clock Edge Generator

This block produces the fast horizontal clocks, the reset gate and the two sample strobes for a CCD readout front end. A fast clock runs at `TICKS` ticks per pixel period (48 by default). A phase counter steps through those ticks and wraps at the end of each pixel. Three primary waveforms, H1, H3 and RG, each have their own rise tick, fall tick and inversion bit. H2 and H4 are always the complements of H1 and H3. The strobes SHP and SHD each fire for exactly one tick, at a programmed tick of the pixel.

Software writes settings through a plain address/data write port into a pending copy. That pending copy moves into the working copy only at the pixel boundary, so a pixel never mixes old and new settings. Each of the five clock pins has a 3-bit drive code. A code of zero disables that pin, and the pin's enable output is then low so the pad can be tri-stated. Location fields that are written with a value above `TICKS-1` are stored as `TICKS-1`.

Top module: `pixclk_edge_gen`

## Requirements
- R1: The phase counter counts 0 to TICKS-1 and then wraps to 0. `pix_start` is high exactly in the tick where the count is 0.
- R2: For each of H1, H3 and RG, the un-inverted level is 1 during the tick whose count equals the rise location and 0 during the tick whose count equals the fall location. In every other tick it keeps the previous tick's level. High periods may wrap across the pixel boundary.
- R3: Polarity bit 0 passes the level unchanged and bit 1 inverts it.
- R4: `h_lvl` bit 0 is H1, bit 1 is H2 = not H1, bit 2 is H3 and bit 3 is H4 = not H3.
- R5: `shp` (`shd`) is high exactly in the ticks whose count equals the SHP (SHD) location.
- R6: `out_en` bits 0..4 belong to H1, H2, H3, H4 and RG. Each bit is 0 when that pin's drive code is 0 and 1 otherwise.
- R7: When the rise and fall locations of a waveform are equal, the waveform keeps its level for the whole pixel and never toggles.
- R8: A write takes effect from the first tick (count 0) of the pixel after the tick it was captured in. A write captured at the edge that ends tick TICKS-1 therefore takes effect one pixel later still.
- R9: A location value above TICKS-1 is stored and used as TICKS-1.
- R10: Reset clears every setting to zero and the counter to 0. While in reset, `pix_start`, `shp` and `shd` are 1, `h_lvl` is 4'b1010, `rg_lvl` is 0 and `out_en` is 0.
- R11: Register map:
  - Address 0 sets H1, address 1 sets H3 and address 2 sets RG. Each takes rise [5:0], fall [11:6], polarity [12] and drive [15:13].
  - Address 3 takes the SHP location in [5:0] and the SHD location in [11:6].
  - Address 4 takes the H2 drive in [2:0] and the H4 drive in [5:3].
  - Writes to addresses 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| pix_start | output | 1 | High in tick 0 of every pixel |
| h_lvl | output | 4 | H1, H2, H3, H4 levels (bit 0 = H1) |
| rg_lvl | output | 1 | Reset gate level |
| out_en | output | 5 | Pin enables for H1, H2, H3, H4 and RG |
| shp | output | 1 | Reset-level sample strobe |
| shd | output | 1 | Data-level sample strobe |

## Verification
The assertions check the following on every cycle:
- the counter stays in range and wraps correctly;
- the working settings change only at the pixel boundary and never hold a location above the last tick;
- a waveform with equal rise and fall locations holds its level;
- the level registered after a rise or fall tick is correct;
- a strobe lasts a single tick within a pixel.

Only the bench scenarios can show the complete waveforms under polarity, wrap-around high periods, clamping and drive-code enables. They also show that a write is deferred by one or two pixels depending on the tick in which it lands, and that unused addresses are ignored.

// File: rtl/pce_pkg.sv
package pce_pkg;
   localparam int PCE_LOC_W = 6;
   localparam int PCE_DRV_W = 3;
   localparam int PCE_NCH   = 3;   // H1, H3, RG
   localparam int PCE_AW    = 3;
   localparam int PCE_DW    = 2 * PCE_LOC_W + 1 + PCE_DRV_W;

   localparam logic [PCE_AW-1:0] PCE_A_SAMPLE = 3'd3;
   localparam logic [PCE_AW-1:0] PCE_A_AUXDRV = 3'd4;

   typedef logic [PCE_LOC_W-1:0] loc_t;
   typedef logic [PCE_DRV_W-1:0] drv_t;

   typedef struct packed {
      drv_t drv;
      logic pol;
      loc_t fall;
      loc_t rise;
   } edge_cfg_t;

   function automatic loc_t pce_clamp(input loc_t v, input loc_t mx);
      return (v > mx) ? mx : v;
   endfunction
endpackage

// File: rtl/pce_phase_ctr.sv
module pce_phase_ctr
   import pce_pkg::*;
#(
   parameter int TICKS = 48
) (
   input  logic clk,
   input  logic rst_n,
   output loc_t cnt,
   output logic first,
   output logic last
);
   localparam loc_t MAXC = loc_t'(TICKS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (last)   cnt <= '0;
      else             cnt <= cnt + loc_t'(1);
   end

   assign first = (cnt == '0);
   assign last  = (cnt == MAXC);

   // R1
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= MAXC);
   // R1
   cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n) last |=> (cnt == '0));
endmodule

// File: rtl/pce_cfg_regs.sv
module pce_cfg_regs
   import pce_pkg::*;
#(
   parameter int TICKS = 48
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [PCE_AW-1:0]        wr_addr,
   input  logic [PCE_DW-1:0]        wr_data,
   input  logic                     load,
   output edge_cfg_t [PCE_NCH-1:0]  act_edge,
   output loc_t                     act_shp,
   output loc_t                     act_shd,
   output drv_t                     act_h2_drv,
   output drv_t                     act_h4_drv
);
   localparam loc_t MAXL = loc_t'(TICKS - 1);

   edge_cfg_t [PCE_NCH-1:0] pend_edge;
   loc_t pend_shp, pend_shd;
   drv_t pend_h2_drv, pend_h4_drv;
   edge_cfg_t wr_edge;

   always_comb begin
      wr_edge      = edge_cfg_t'(wr_data);
      wr_edge.rise = pce_clamp(wr_edge.rise, MAXL);
      wr_edge.fall = pce_clamp(wr_edge.fall, MAXL);
   end

   for (genvar g = 0; g < PCE_NCH; g++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_edge[g] <= '0;
            act_edge[g]  <= '0;
         end else begin
            if (load)
               act_edge[g] <= pend_edge[g];
            if (wr_en && wr_addr == PCE_AW'(g))
               pend_edge[g] <= wr_edge;
         end
      end
      // R9
      loc_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (act_edge[g].rise <= MAXL) && (act_edge[g].fall <= MAXL));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_shp <= '0; pend_shd <= '0;
         pend_h2_drv <= '0; pend_h4_drv <= '0;
         act_shp <= '0; act_shd <= '0;
         act_h2_drv <= '0; act_h4_drv <= '0;
      end else begin
         if (load) begin
            act_shp <= pend_shp;
            act_shd <= pend_shd;
            act_h2_drv <= pend_h2_drv;
            act_h4_drv <= pend_h4_drv;
         end
         if (wr_en && wr_addr == PCE_A_SAMPLE) begin
            pend_shp <= pce_clamp(wr_data[PCE_LOC_W-1:0], MAXL);
            pend_shd <= pce_clamp(wr_data[2*PCE_LOC_W-1:PCE_LOC_W], MAXL);
         end
         if (wr_en && wr_addr == PCE_A_AUXDRV) begin
            pend_h2_drv <= wr_data[PCE_DRV_W-1:0];
            pend_h4_drv <= wr_data[2*PCE_DRV_W-1:PCE_DRV_W];
         end
      end
   end

   // R8
   act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(act_edge) && $stable(act_shp) && $stable(act_shd)
                 && $stable(act_h2_drv) && $stable(act_h4_drv)));
   // R9
   strobe_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_shp <= MAXL) && (act_shd <= MAXL));
endmodule

// File: rtl/pce_edge_unit.sv
module pce_edge_unit
   import pce_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  loc_t      cnt,
   input  edge_cfg_t cfg,
   output logic      lvl
);
   logic base_q;
   logic base_d;
   logic active;

   assign active = (cfg.rise != cfg.fall);

   always_comb begin
      base_d = base_q;
      if (active && cnt == cfg.rise)      base_d = 1'b1;
      else if (active && cnt == cfg.fall) base_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) base_q <= 1'b0;
      else        base_q <= base_d;
   end

   assign lvl = base_d ^ cfg.pol;

   // R7
   equal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.rise == cfg.fall) |=> (base_q == $past(base_q)));
   // R2
   rise_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && cnt == cfg.rise) |=> base_q);
   // R2
   fall_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && cnt == cfg.fall) |=> !base_q);
endmodule

// File: rtl/pixclk_edge_gen.sv
module pixclk_edge_gen
   import pce_pkg::*;
#(
   parameter int TICKS = 48
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [2:0]  wr_addr,
   input  logic [15:0] wr_data,
   output logic        pix_start,
   output logic [3:0]  h_lvl,
   output logic        rg_lvl,
   output logic [4:0]  out_en,
   output logic        shp,
   output logic        shd
);
   if (TICKS < 4 || TICKS > (1 << PCE_LOC_W)) begin : g_bad_ticks
      $error("pixclk_edge_gen: TICKS out of range");
   end
   if (PCE_DW != 16) begin : g_bad_dw
      $error("pixclk_edge_gen: write data width mismatch");
   end

   loc_t cnt;
   logic last;
   edge_cfg_t [PCE_NCH-1:0] act_edge;
   loc_t act_shp, act_shd;
   drv_t act_h2_drv, act_h4_drv;
   logic [PCE_NCH-1:0] ch_lvl;

   pce_phase_ctr #(.TICKS(TICKS)) u_ctr (
      .clk(clk), .rst_n(rst_n), .cnt(cnt), .first(pix_start), .last(last));

   pce_cfg_regs #(.TICKS(TICKS)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .load(last), .act_edge(act_edge),
      .act_shp(act_shp), .act_shd(act_shd),
      .act_h2_drv(act_h2_drv), .act_h4_drv(act_h4_drv));

   for (genvar g = 0; g < PCE_NCH; g++) begin : g_edge
      pce_edge_unit u_eu (
         .clk(clk), .rst_n(rst_n), .cnt(cnt), .cfg(act_edge[g]), .lvl(ch_lvl[g]));
   end

   assign h_lvl  = {~ch_lvl[1], ch_lvl[1], ~ch_lvl[0], ch_lvl[0]};
   assign rg_lvl = ch_lvl[2];
   assign out_en = {act_edge[2].drv != '0, act_h4_drv != '0, act_edge[1].drv != '0,
                    act_h2_drv != '0, act_edge[0].drv != '0};
   assign shp = (cnt == act_shp);
   assign shd = (cnt == act_shd);

   // R5
   shp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shp && !last) |=> !shp);
   // R5
   shd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shd && !last) |=> !shd);
   // R1
   pix_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pix_start |=> !pix_start);
endmodule

// File: tb/pixclk_edge_gen_bench.sv
module pixclk_edge_gen_bench;
   localparam int T = 48;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic pix_start, rg_lvl, shp, shd;
   logic [3:0] h_lvl;
   logic [4:0] out_en;

   int total = 0;
   int bad = 0;
   string tag = "R10 reset";

   int mcnt;
   logic [15:0] pend [5];
   logic [15:0] act [5];
   logic mbase [3];

   always #4 clk = ~clk;

   pixclk_edge_gen #(.TICKS(T)) u_pixclk_edge_gen (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .pix_start(pix_start), .h_lvl(h_lvl), .rg_lvl(rg_lvl), .out_en(out_en),
      .shp(shp), .shd(shd));

   function automatic logic [5:0] bclamp(input logic [5:0] v);
      return (v > 6'(T - 1)) ? 6'(T - 1) : v;
   endfunction

   function automatic logic [15:0] mk(input int rise, input int fall, input bit pol, input int drv);
      return {3'(drv), pol, 6'(fall), 6'(rise)};
   endfunction

   task automatic chk(input string name, input logic [4:0] a, input logic [4:0] e);
      total++;
      if (a !== e) begin
         bad++;
         $display("FAIL %s [%s] tick=%0d actual=%b expected=%b", name, tag, mcnt, a, e);
      end
   endtask

   // Check current tick against the model, then advance the model by one edge.
   task automatic check_and_model(input bit we, input logic [2:0] a, input logic [15:0] d);
      logic lv [3];
      for (int ch = 0; ch < 3; ch++) begin
         logic [5:0] r, f;
         logic e;
         r = act[ch][5:0];
         f = act[ch][11:6];
         e = mbase[ch];
         if (r != f) begin
            if (mcnt == int'(r)) e = 1'b1;
            else if (mcnt == int'(f)) e = 1'b0;
         end
         mbase[ch] = e;
         lv[ch] = e ^ act[ch][12];
      end
      chk("h_lvl R2 R3 R4 R7", {1'b0, h_lvl}, {1'b0, ~lv[1], lv[1], ~lv[0], lv[0]});
      chk("rg_lvl R2 R3", {4'b0, rg_lvl}, {4'b0, lv[2]});
      chk("out_en R6", out_en, {act[2][15:13] != 0, act[4][5:3] != 0, act[1][15:13] != 0,
                                act[4][2:0] != 0, act[0][15:13] != 0});
      chk("shp shd R5", {3'b0, shp, shd},
          {3'b0, mcnt == int'(act[3][5:0]), mcnt == int'(act[3][11:6])});
      chk("pix_start R1", {4'b0, pix_start}, {4'b0, mcnt == 0});
      if (rst_n) begin
         if (mcnt == T - 1)
            for (int i = 0; i < 5; i++) act[i] = pend[i];
         if (we) begin
            if (a <= 3'd2) pend[a] = {d[15:12], bclamp(d[11:6]), bclamp(d[5:0])};
            else if (a == 3'd3) pend[3] = {4'b0, bclamp(d[11:6]), bclamp(d[5:0])};
            else if (a == 3'd4) pend[4] = {10'b0, d[5:0]};
         end
         mcnt = (mcnt == T - 1) ? 0 : mcnt + 1;
      end
   endtask

   // Called at a falling edge; returns at the next falling edge.
   task automatic step(input bit we, input logic [2:0] a, input logic [15:0] d);
      check_and_model(we, a, d);
      wr_en = we;
      wr_addr = a;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 3'd0, 16'h0);
   endtask

   task automatic run_to(input int c);
      while (mcnt != c) step(1'b0, 3'd0, 16'h0);
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog [%s] run did not complete", tag);
      finish_run();
   end

   initial begin
      void'($urandom(32'd1234));
      mcnt = 0;
      for (int i = 0; i < 5; i++) begin pend[i] = '0; act[i] = '0; end
      for (int i = 0; i < 3; i++) mbase[i] = 1'b0;

      repeat (3) @(negedge clk);
      tag = "R10 reset";
      check_and_model(1'b0, 3'd0, 16'h0);
      rst_n = 1'b1;
      idle(T + 3);

      tag = "R2 R3 R7 R11 directed setup";
      run_to(10);
      step(1'b1, 3'd0, mk(5, 20, 1'b0, 3));
      step(1'b1, 3'd1, mk(30, 10, 1'b1, 7));
      step(1'b1, 3'd2, mk(7, 7, 1'b0, 1));
      step(1'b1, 3'd3, {4'b0, 6'd40, 6'd12});
      step(1'b1, 3'd4, 16'h0002);
      tag = "R8 deferred to next pixel";
      idle(3 * T);

      tag = "R8 write in last tick";
      run_to(T - 1);
      step(1'b1, 3'd0, mk(1, 2, 1'b1, 0));
      idle(2 * T + 5);

      tag = "R9 clamp";
      step(1'b1, 3'd0, mk(2, 60, 1'b0, 5));
      step(1'b1, 3'd3, {4'b0, 6'd63, 6'd50});
      step(1'b1, 3'd2, mk(63, 40, 1'b1, 2));
      idle(2 * T + 2);

      tag = "R11 unused address";
      step(1'b1, 3'd5, 16'hFFFF);
      step(1'b1, 3'd6, 16'hFFFF);
      step(1'b1, 3'd7, 16'hFFFF);
      idle(2 * T);

      tag = "R7 equal hold after high";
      step(1'b1, 3'd1, mk(9, 9, 1'b0, 4));
      idle(2 * T);

      tag = "R2 R3 R5 R6 R8 random";
      for (int p = 0; p < 60 * T; p++) begin
         if (($urandom % 8) == 0)
            step(1'b1, 3'($urandom % 8), 16'($urandom));
         else
            step(1'b0, 3'd0, 16'h0);
      end

      finish_run();
   end
endmodule